// File: doc/BRIEF.md
# Shared-Memory Message Channel Engine

This block is the coprocessor side of a channelized mailbox that a host and a coprocessor share through a byte-wide RAM. The RAM holds two regions: a send region, where the host posts messages for the coprocessor, and a receive region, where the coprocessor posts unsolicited messages for the host. Each region holds a channel-count byte, one handshake byte per channel and one fixed 32-byte buffer per channel. The block scans the send handshake bytes, claims a newly posted message, streams it out to a local consumer, writes the consumer's reply over the message in place and marks the channel complete. Between scans it accepts an unsolicited message from a local producer, writes it into a free receive buffer, marks it new and raises a host interrupt pulse.

The engine is one state machine. After reset it walks INIT_TXMAX, INIT_RXMAX and INIT_ALIVE, which publish the channel counts and the alive byte. It then loops SCAN_RD → SCAN_CHK. From SCAN_CHK a new send message leads to CLAIM → MSG_RD ⇄ MSG_OUT (one pair per byte, MSG_OUT waiting on the consumer) → REPLY (32 reply bytes) → FINISH → SCAN_RD. When the scanned channel holds nothing new and a post is waiting, SCAN_CHK leads to POST_RD → POST_CHK. A busy receive channel sends POST_CHK back to SCAN_RD. A free one leads to POST_IN (32 bytes) → POST_SET → SCAN_RD. Otherwise SCAN_CHK returns to SCAN_RD on the next channel.

The RAM port is a single port with no wait states: a write takes effect at the clock edge where `ram_req` and `ram_we` are both high. Read data appears on `ram_rdata` in the cycle after the read request and holds until the next read. `post_chan` must stay below the channel count and stay stable while `post_valid` is high.

Top module: `mbx_engine`

## Requirements
- R1: After reset the first three RAM accesses are writes, in this order: the channel count 7 to 0x200, 7 to 0x300, then 0xFF to the alive byte at 0x31F. No channel is read or written before the alive write.
- R2: For channel n (0..6), the handshake byte is at region base + 1 + n and the buffer is at region base + 0x20 + 32·n. The region base is 0x200 for send and 0x300 for receive. The byte at 0x21F is never written.
- R3: Handshake codes are 0 idle, 1 new, 2 received, 3 complete. On finding 1 on a send channel, the engine writes 2 there before it offers the first message byte.
- R4: The 32 message bytes leave on `out_data` in ascending address order, with `out_chan` = n and `out_last` high only on the 32nd byte. While `out_ready` is low, a byte that is offered stays offered and unchanged.
- R5: Only after the last message byte is taken does the engine raise `rep_ready`. It takes 32 reply bytes, writes them over the message buffer in order, then writes 3 to the handshake byte.
- R6: A send channel holding 0, 2 or 3 is neither streamed nor written.
- R7: Channels are scanned in ascending order with wrap-around, and scanning resumes at n+1 (mod 7) after channel n is serviced.
- R8: When the scanned send channel holds 1 and a post is waiting, the send message is serviced first. The post is only considered at a scan step whose channel does not hold 1.
- R9: A post goes ahead only when the target receive handshake byte is 0. Otherwise `post_ready` stays low and the receive buffer is untouched.
- R10: An accepted post writes its 32 bytes into the receive buffer, then writes 1 to the receive handshake byte. `host_irq` is high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write enable (with ram_req) |
| ram_addr | output | 12 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after a read |
| out_valid | output | 1 | Message byte offered to consumer |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Message byte |
| out_chan | output | 3 | Send channel of the message |
| out_last | output | 1 | Last byte of the message |
| rep_valid | input | 1 | Reply byte offered |
| rep_ready | output | 1 | Engine takes reply byte |
| rep_data | input | 8 | Reply byte |
| post_valid | input | 1 | Unsolicited byte offered |
| post_ready | output | 1 | Engine takes unsolicited byte |
| post_chan | input | 3 | Target receive channel of the post |
| post_data | input | 8 | Unsolicited message byte |
| host_irq | output | 1 | One-cycle interrupt pulse to the host |

## Verification
The two functions that can compete in the same cycle are servicing a newly posted send message and accepting a waiting unsolicited post. Both become eligible at the SCAN_CHK decision. The bench provokes this by holding the consumer on channel 2 while it marks channel 3 new and raises `post_valid` for receive channel 0. When channel 2 finishes, the scan resumes at channel 3. The result is judged by checking that the channel 3 message streams completely while `post_ready` never rises. After that the post must complete with its interrupt pulse and buffer contents intact.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int BYTE_W = 8;

    // handshake byte codes
    localparam logic [BYTE_W-1:0] HS_IDLE = 8'd0;
    localparam logic [BYTE_W-1:0] HS_NEW  = 8'd1;
    localparam logic [BYTE_W-1:0] HS_RCVD = 8'd2;
    localparam logic [BYTE_W-1:0] HS_DONE = 8'd3;

    localparam logic [BYTE_W-1:0] ALIVE_MARK = 8'hFF;

    typedef enum logic [3:0] {
        ST_INIT_TXMAX,
        ST_INIT_RXMAX,
        ST_INIT_ALIVE,
        ST_SCAN_RD,
        ST_SCAN_CHK,
        ST_CLAIM,
        ST_MSG_RD,
        ST_MSG_OUT,
        ST_REPLY,
        ST_FINISH,
        ST_POST_RD,
        ST_POST_CHK,
        ST_POST_IN,
        ST_POST_SET
    } mbx_state_e;

    typedef enum logic [1:0] {
        AK_COUNT,
        AK_HSHAKE,
        AK_BUFFER,
        AK_ALIVE
    } mbx_kind_e;

endpackage

// File: rtl/mbx_addr_gen.sv
module mbx_addr_gen
    import mbx_pkg::*;
#(
    parameter int NUM_CH  = 7,
    parameter int MSG_LEN = 32,
    parameter int AW      = 12,
    parameter int CW      = 3,
    parameter int BW      = 5,
    parameter int TX_BASE = 'h200,
    parameter int RX_BASE = 'h300
) (
    input  logic            rx_sel,
    input  mbx_kind_e       kind,
    input  logic [CW-1:0]   chan,
    input  logic [BW-1:0]   beat,
    output logic [AW-1:0]   addr
);

    localparam logic [AW-1:0] BUF_OFS   = AW'(MSG_LEN);
    localparam logic [AW-1:0] ALIVE_OFS = AW'(MSG_LEN - 1);

    logic [AW-1:0] base;
    logic [AW-1:0] ofs;

    always_comb begin
        base = rx_sel ? AW'(RX_BASE) : AW'(TX_BASE);
        unique case (kind)
            AK_COUNT:  ofs = '0;
            AK_HSHAKE: ofs = AW'(chan) + AW'(1);
            AK_BUFFER: ofs = BUF_OFS + AW'(chan) * AW'(MSG_LEN) + AW'(beat);
            AK_ALIVE:  ofs = ALIVE_OFS;
            default:   ofs = '0;
        endcase
        addr = base + ofs;
    end

endmodule

// File: rtl/mbx_rr_ptr.sv
module mbx_rr_ptr #(
    parameter int NUM_CH = 7,
    parameter int CW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [CW-1:0] ptr
);

    localparam logic [CW-1:0] TOP = CW'(NUM_CH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == TOP) ? '0 : ptr + CW'(1);
        end
    end

endmodule

// File: rtl/mbx_beat_cnt.sv
module mbx_beat_cnt #(
    parameter int MSG_LEN = 32,
    parameter int BW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [BW-1:0] cnt,
    output logic          last
);

    localparam logic [BW-1:0] FINAL = BW'(MSG_LEN - 1);

    assign last = (cnt == FINAL);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= last ? '0 : cnt + BW'(1);
        end
    end

endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
    import mbx_pkg::*;
#(
    parameter int NUM_CH  = 7,
    parameter int MSG_LEN = 32,
    parameter int AW      = 12,
    parameter int TX_BASE = 'h200,
    parameter int RX_BASE = 'h300
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        ram_req,
    output logic        ram_we,
    output logic [11:0] ram_addr,
    output logic [7:0]  ram_wdata,
    input  logic [7:0]  ram_rdata,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data,
    output logic [2:0]  out_chan,
    output logic        out_last,
    input  logic        rep_valid,
    output logic        rep_ready,
    input  logic [7:0]  rep_data,
    input  logic        post_valid,
    output logic        post_ready,
    input  logic [2:0]  post_chan,
    input  logic [7:0]  post_data,
    output logic        host_irq
);

    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int BW = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1;
    localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_CH);

    mbx_state_e     state, nxt;
    logic [CW-1:0]  scan_ptr;
    logic [CW-1:0]  cur_ch;
    logic [CW-1:0]  chan_sel;
    logic [BW-1:0]  beat;
    logic           beat_last;
    logic           beat_inc;
    logic           beat_clr;
    logic           ptr_adv;
    logic           rx_sel;
    mbx_kind_e      kind;
    logic [AW-1:0]  addr_w;

    mbx_rr_ptr #(.NUM_CH(NUM_CH), .CW(CW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ptr_adv),
        .ptr   (scan_ptr)
    );

    mbx_beat_cnt #(.MSG_LEN(MSG_LEN), .BW(BW)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (beat_clr),
        .inc   (beat_inc),
        .cnt   (beat),
        .last  (beat_last)
    );

    mbx_addr_gen #(
        .NUM_CH(NUM_CH), .MSG_LEN(MSG_LEN), .AW(AW), .CW(CW), .BW(BW),
        .TX_BASE(TX_BASE), .RX_BASE(RX_BASE)
    ) u_addr (
        .rx_sel (rx_sel),
        .kind   (kind),
        .chan   (chan_sel),
        .beat   (beat),
        .addr   (addr_w)
    );

    assign ram_addr = 12'(addr_w);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_INIT_TXMAX;
        end else begin
            state <= nxt;
        end
    end

    // channel under service
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch <= '0;
        end else if (state == ST_SCAN_CHK && ram_rdata == HS_NEW) begin
            cur_ch <= scan_ptr;
        end else if (state == ST_POST_RD) begin
            cur_ch <= CW'(post_chan);
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_INIT_TXMAX: nxt = ST_INIT_RXMAX;
            ST_INIT_RXMAX: nxt = ST_INIT_ALIVE;
            ST_INIT_ALIVE: nxt = ST_SCAN_RD;
            ST_SCAN_RD:    nxt = ST_SCAN_CHK;
            ST_SCAN_CHK: begin
                if (ram_rdata == HS_NEW)  nxt = ST_CLAIM;
                else if (post_valid)      nxt = ST_POST_RD;
                else                      nxt = ST_SCAN_RD;
            end
            ST_CLAIM:      nxt = ST_MSG_RD;
            ST_MSG_RD:     nxt = ST_MSG_OUT;
            ST_MSG_OUT: begin
                if (out_ready) nxt = beat_last ? ST_REPLY : ST_MSG_RD;
            end
            ST_REPLY: begin
                if (rep_valid && beat_last) nxt = ST_FINISH;
            end
            ST_FINISH:     nxt = ST_SCAN_RD;
            ST_POST_RD:    nxt = ST_POST_CHK;
            ST_POST_CHK:   nxt = (ram_rdata == HS_IDLE) ? ST_POST_IN : ST_SCAN_RD;
            ST_POST_IN: begin
                if (post_valid && beat_last) nxt = ST_POST_SET;
            end
            ST_POST_SET:   nxt = ST_SCAN_RD;
            default:       nxt = ST_INIT_TXMAX;
        endcase
    end

    // outputs
    always_comb begin
        ram_req    = 1'b0;
        ram_we     = 1'b0;
        ram_wdata  = '0;
        rx_sel     = 1'b0;
        kind       = AK_HSHAKE;
        chan_sel   = cur_ch;
        out_valid  = 1'b0;
        rep_ready  = 1'b0;
        post_ready = 1'b0;
        host_irq   = 1'b0;
        ptr_adv    = 1'b0;
        beat_clr   = 1'b0;
        beat_inc   = 1'b0;
        unique case (state)
            ST_INIT_TXMAX: begin
                ram_req = 1'b1; ram_we = 1'b1; kind = AK_COUNT;
                ram_wdata = COUNT_BYTE;
            end
            ST_INIT_RXMAX: begin
                ram_req = 1'b1; ram_we = 1'b1; kind = AK_COUNT; rx_sel = 1'b1;
                ram_wdata = COUNT_BYTE;
            end
            ST_INIT_ALIVE: begin
                ram_req = 1'b1; ram_we = 1'b1; kind = AK_ALIVE; rx_sel = 1'b1;
                ram_wdata = ALIVE_MARK;
            end
            ST_SCAN_RD: begin
                ram_req = 1'b1; chan_sel = scan_ptr;
            end
            ST_SCAN_CHK: begin
                beat_clr = 1'b1;
                ptr_adv  = (ram_rdata != HS_NEW);
            end
            ST_CLAIM: begin
                ram_req = 1'b1; ram_we = 1'b1; ram_wdata = HS_RCVD;
            end
            ST_MSG_RD: begin
                ram_req = 1'b1; kind = AK_BUFFER;
            end
            ST_MSG_OUT: begin
                out_valid = 1'b1;
                beat_inc  = out_ready;
            end
            ST_REPLY: begin
                rep_ready = 1'b1;
                kind      = AK_BUFFER;
                ram_req   = rep_valid;
                ram_we    = rep_valid;
                ram_wdata = rep_data;
                beat_inc  = rep_valid;
            end
            ST_FINISH: begin
                ram_req = 1'b1; ram_we = 1'b1; ram_wdata = HS_DONE;
                ptr_adv = 1'b1;
            end
            ST_POST_RD: begin
                ram_req = 1'b1; rx_sel = 1'b1; chan_sel = CW'(post_chan);
            end
            ST_POST_CHK: begin
                beat_clr = 1'b1;
            end
            ST_POST_IN: begin
                post_ready = 1'b1;
                rx_sel     = 1'b1;
                kind       = AK_BUFFER;
                ram_req    = post_valid;
                ram_we     = post_valid;
                ram_wdata  = post_data;
                beat_inc   = post_valid;
            end
            ST_POST_SET: begin
                ram_req = 1'b1; ram_we = 1'b1; rx_sel = 1'b1;
                ram_wdata = HS_NEW;
                host_irq  = 1'b1;
            end
            default: begin
                ram_req = 1'b0;
            end
        endcase
    end

    assign out_data = ram_rdata;
    assign out_chan = 3'(cur_ch);
    assign out_last = out_valid && beat_last;

endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk #(
    parameter int NUM_CH  = 7,
    parameter int MSG_LEN = 32,
    parameter int TX_BASE = 'h200,
    parameter int RX_BASE = 'h300
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ram_req,
    input logic        ram_we,
    input logic [11:0] ram_addr,
    input logic [7:0]  ram_wdata,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_data,
    input logic [2:0]  out_chan,
    input logic        out_last,
    input logic        rep_ready,
    input logic        post_ready,
    input logic        host_irq
);

    localparam logic [11:0] TX_CNT_A = 12'(TX_BASE);
    localparam logic [11:0] RX_CNT_A = 12'(RX_BASE);
    localparam logic [11:0] ALIVE_A  = 12'(RX_BASE + MSG_LEN - 1);
    localparam logic [11:0] PATCH_A  = 12'(TX_BASE + MSG_LEN - 1);
    localparam logic [11:0] RX_HS_LO = 12'(RX_BASE + 1);
    localparam logic [11:0] RX_HS_HI = 12'(RX_BASE + NUM_CH);

    logic alive_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alive_seen <= 1'b0;
        end else if (ram_req && ram_we && ram_addr == ALIVE_A) begin
            alive_seen <= 1'b1;
        end
    end

    // R1
    init_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req && !alive_seen |->
            ram_we && (ram_addr == TX_CNT_A || ram_addr == RX_CNT_A || ram_addr == ALIVE_A));

    // R2
    patch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req && ram_we |-> ram_addr != PATCH_A);

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=>
            out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_last));

    // R5
    reply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_ready |-> !out_valid && !post_ready);

    // R10
    irq_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> ram_req && ram_we && ram_wdata == 8'd1 &&
                     ram_addr >= RX_HS_LO && ram_addr <= RX_HS_HI);

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |=> !host_irq);

    // R9
    post_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_ready |-> !out_valid && !host_irq);

endmodule

bind mbx_engine mbx_engine_chk #(
    .NUM_CH(NUM_CH), .MSG_LEN(MSG_LEN), .TX_BASE(TX_BASE), .RX_BASE(RX_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ram_req    (ram_req),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_chan   (out_chan),
    .out_last   (out_last),
    .rep_ready  (rep_ready),
    .post_ready (post_ready),
    .host_irq   (host_irq)
);

// File: tb/test_mbx_engine.sv
module test_mbx_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_req, ram_we;
    logic [11:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = 8'h00;
    logic        out_valid, out_last;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic [2:0]  out_chan;
    logic        rep_valid = 1'b0;
    logic        rep_ready;
    logic [7:0]  rep_data = 8'h00;
    logic        post_valid = 1'b0;
    logic        post_ready;
    logic [2:0]  post_chan = 3'd0;
    logic [7:0]  post_data = 8'h00;
    logic        host_irq;

    // host-side write port into the shared RAM model
    logic        h_we = 1'b0;
    logic [11:0] h_addr = 12'h0;
    logic [7:0]  h_data = 8'h0;

    logic [7:0]  mem [1024] = '{default: 8'h00};
    int          acc_n = 0;
    logic [11:0] acc_addr [3];
    logic        acc_we   [3];
    logic [7:0]  acc_dat  [3];
    int          irq_cnt = 0;
    int          prdy_cnt = 0;
    int          oval_cnt = 0;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mbx_engine i_mbx_engine (
        .clk(clk), .rst_n(rst_n),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_chan(out_chan), .out_last(out_last),
        .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_data(rep_data),
        .post_valid(post_valid), .post_ready(post_ready), .post_chan(post_chan),
        .post_data(post_data), .host_irq(host_irq)
    );

    // RAM model plus monitors
    always @(posedge clk) begin
        if (h_we) mem[h_addr[9:0]] <= h_data;
        if (ram_req) begin
            if (ram_we) mem[ram_addr[9:0]] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr[9:0]];
        end
        if (rst_n) begin
            if (ram_req && acc_n < 3) begin
                acc_addr[acc_n] <= ram_addr;
                acc_we[acc_n]   <= ram_we;
                acc_dat[acc_n]  <= ram_wdata;
                acc_n <= acc_n + 1;
            end
            if (host_irq)   irq_cnt  <= irq_cnt + 1;
            if (post_ready) prdy_cnt <= prdy_cnt + 1;
            if (out_valid)  oval_cnt <= oval_cnt + 1;
        end
    end

    typedef struct packed {
        logic [2:0] ch;
        logic       stall;
        logic [7:0] seed;
        logic [7:0] rseed;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{3'd0, 1'b0, 8'h10, 8'h5A},
        '{3'd6, 1'b1, 8'h80, 8'hC3},
        '{3'd3, 1'b0, 8'hE0, 8'h0F},
        '{3'd1, 1'b1, 8'h21, 8'hF0},
        '{3'd4, 1'b0, 8'h44, 8'h99}
    };

    function automatic logic [11:0] hs_a(input logic rx, input int ch);
        return (rx ? 12'h300 : 12'h200) + 12'(1 + ch);
    endfunction

    function automatic logic [11:0] buf_a(input logic rx, input int ch, input int i);
        return (rx ? 12'h300 : 12'h200) + 12'(32 + 32 * ch + i);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [11:0] a, input logic [7:0] d);
        h_we = 1'b1; h_addr = a; h_data = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic load_msg(input int ch, input logic [7:0] seed);
        for (int i = 0; i < 32; i++) host_wr(buf_a(1'b0, ch, i), seed + 8'(i));
        host_wr(hs_a(1'b0, ch), 8'd1);
    endtask

    task automatic consume(input int ch, input logic [7:0] seed, input logic stall);
        for (int i = 0; i < 32; i++) begin
            while (!out_valid) @(negedge clk);
            if (i == 0)
                chk(mem[hs_a(1'b0, ch)[9:0]] == 8'd2, "R3 claim", 32'(mem[hs_a(1'b0, ch)[9:0]]), 2);
            chk(out_data == seed + 8'(i) && out_chan == 3'(ch) && out_last == (i == 31), "R4 byte",
                {20'h0, out_chan, out_last, out_data}, {20'h0, 3'(ch), 1'(i == 31), seed + 8'(i)});
            if (stall) begin
                @(negedge clk);
                chk(out_valid && out_data == seed + 8'(i), "R4 hold",
                    {23'h0, out_valid, out_data}, {23'h0, 1'b1, seed + 8'(i)});
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
    endtask

    task automatic give_reply(input logic [7:0] rseed);
        for (int i = 0; i < 32; i++) begin
            rep_valid = 1'b1;
            rep_data  = rseed ^ 8'(i);
            while (!rep_ready) @(negedge clk);
            @(negedge clk);
        end
        rep_valid = 1'b0;
    endtask

    task automatic verify_done(input int ch, input logic [7:0] rseed);
        int bad = 0;
        repeat (3) @(negedge clk);
        chk(mem[hs_a(1'b0, ch)[9:0]] == 8'd3, "R5 state", 32'(mem[hs_a(1'b0, ch)[9:0]]), 3);
        for (int i = 0; i < 32; i++)
            if (mem[buf_a(1'b0, ch, i)[9:0]] != (rseed ^ 8'(i))) bad++;
        chk(bad == 0, "R5 reply in place", 32'(bad), 0);
    endtask

    task automatic feed_post(input int ch, input logic [7:0] seed);
        post_chan = 3'(ch);
        for (int i = 0; i < 32; i++) begin
            post_valid = 1'b1;
            post_data  = seed + 8'(i);
            while (!post_ready) @(negedge clk);
            @(negedge clk);
        end
        post_valid = 1'b0;
    endtask

    task automatic verify_post(input int ch, input logic [7:0] seed, input int irq0);
        int bad = 0;
        repeat (3) @(negedge clk);
        chk(mem[hs_a(1'b1, ch)[9:0]] == 8'd1, "R10 state", 32'(mem[hs_a(1'b1, ch)[9:0]]), 1);
        for (int i = 0; i < 32; i++)
            if (mem[buf_a(1'b1, ch, i)[9:0]] != seed + 8'(i)) bad++;
        chk(bad == 0, "R10 buffer", 32'(bad), 0);
        chk(irq_cnt == irq0 + 1, "R10 irq", 32'(irq_cnt), 32'(irq0 + 1));
    endtask

    initial begin
        int snap;
        int irq0;
        repeat (5) @(negedge clk);
        chk(!out_valid && !rep_ready && !post_ready && !host_irq, "reset outputs",
            {28'h0, out_valid, rep_ready, post_ready, host_irq}, 0);
        rst_n = 1'b1;
        host_wr(12'h21F, 8'hA5);
        repeat (4) @(negedge clk);

        // R1: init sequence
        chk(acc_we[0] && acc_addr[0] == 12'h200 && acc_dat[0] == 8'd7, "R1 first",
            {acc_addr[0], acc_dat[0]}, {12'h200, 8'd7});
        chk(acc_we[1] && acc_addr[1] == 12'h300 && acc_dat[1] == 8'd7, "R1 second",
            {acc_addr[1], acc_dat[1]}, {12'h300, 8'd7});
        chk(acc_we[2] && acc_addr[2] == 12'h31F && acc_dat[2] == 8'hFF, "R1 alive",
            {acc_addr[2], acc_dat[2]}, {12'h31F, 8'hFF});

        // vector table: R2 R3 R4 R5
        foreach (VEC[k]) begin
            load_msg(int'(VEC[k].ch), VEC[k].seed);
            consume(int'(VEC[k].ch), VEC[k].seed, VEC[k].stall);
            give_reply(VEC[k].rseed);
            verify_done(int'(VEC[k].ch), VEC[k].rseed);
        end

        // R6: states 2, 3 and 0 are left alone
        host_wr(hs_a(1'b0, 5), 8'd2);
        snap = oval_cnt;
        repeat (200) @(negedge clk);
        chk(oval_cnt == snap, "R6 no stream", 32'(oval_cnt), 32'(snap));
        chk(mem[hs_a(1'b0, 5)[9:0]] == 8'd2, "R6 state 2 kept", 32'(mem[hs_a(1'b0, 5)[9:0]]), 2);
        chk(mem[hs_a(1'b0, 0)[9:0]] == 8'd3, "R6 state 3 kept", 32'(mem[hs_a(1'b0, 0)[9:0]]), 3);
        chk(mem[hs_a(1'b0, 2)[9:0]] == 8'd0, "R6 state 0 kept", 32'(mem[hs_a(1'b0, 2)[9:0]]), 0);

        // R7: after channel 5, channel 6 is served before channel 2
        load_msg(5, 8'h50);
        while (!out_valid) @(negedge clk);
        load_msg(2, 8'h20);
        load_msg(6, 8'h60);
        consume(5, 8'h50, 1'b0);
        give_reply(8'hA5);
        verify_done(5, 8'hA5);
        while (!out_valid) @(negedge clk);
        chk(out_chan == 3'd6, "R7 next after 5", 32'(out_chan), 6);
        consume(6, 8'h60, 1'b0);
        give_reply(8'h66);
        verify_done(6, 8'h66);
        consume(2, 8'h20, 1'b0);
        give_reply(8'h22);
        verify_done(2, 8'h22);

        // R8: new send message on the scanned channel beats a waiting post
        load_msg(2, 8'h70);
        while (!out_valid) @(negedge clk);
        load_msg(3, 8'h90);
        post_chan  = 3'd0;
        post_data  = 8'hB0;
        post_valid = 1'b1;
        consume(2, 8'h70, 1'b0);
        give_reply(8'h77);
        snap = prdy_cnt;
        consume(3, 8'h90, 1'b0);
        chk(prdy_cnt == snap, "R8 send first", 32'(prdy_cnt), 32'(snap));
        give_reply(8'h33);
        verify_done(3, 8'h33);
        irq0 = irq_cnt;
        feed_post(0, 8'hB0);
        verify_post(0, 8'hB0, irq0);

        // R9: busy receive channel blocks the post
        host_wr(hs_a(1'b1, 4), 8'd2);
        snap = prdy_cnt;
        irq0 = irq_cnt;
        post_chan  = 3'd4;
        post_data  = 8'hC0;
        post_valid = 1'b1;
        repeat (300) @(negedge clk);
        chk(prdy_cnt == snap, "R9 blocked", 32'(prdy_cnt), 32'(snap));
        chk(mem[buf_a(1'b1, 4, 0)[9:0]] == 8'h00, "R9 buffer untouched",
            32'(mem[buf_a(1'b1, 4, 0)[9:0]]), 0);
        chk(irq_cnt == irq0, "R9 no irq", 32'(irq_cnt), 32'(irq0));
        host_wr(hs_a(1'b1, 4), 8'd0);
        feed_post(4, 8'hC0);
        verify_post(4, 8'hC0, irq0);

        // R2: patch-control byte never written
        chk(mem[10'h21F] == 8'hA5, "R2 patch byte", 32'(mem[10'h21F]), 32'hA5);
        chk(mem[10'h200] == 8'd7 && mem[10'h31F] == 8'hFF, "R2 fixed bytes",
            {16'h0, mem[10'h200], mem[10'h31F]}, {16'h0, 8'd7, 8'hFF});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule